// File: doc/BRIEF.md
# Sequential Boot ROM Emulator

This block stands in for the program ROM while the system starts up. It never looks at the address bus to choose a byte. Instead it keeps a pointer into a fixed byte stream that contains no branches, and it moves the pointer forward once for every enable strobe. While the enable is active on a read, it drives the current byte onto the CPU data bus. Otherwise its output enable is low, so the pad logic outside the block floats the bus.

The stream has three parts. It opens with a two-byte reset vector, low byte first, whose target lies in the upper half of the address space. Next comes one four-byte group per loader byte: a load-immediate opcode with the data byte, then a zero-page store opcode with the destination address. The stream closes with an absolute jump to address zero. Once that jump has been handed out, a done flag rises and the emulator never drives again.

A startup flag routes every CPU read in the upper half of memory to the emulator. The loader, now running from RAM, writes to an exit register to clear the flag. After that, the upper range goes back to its normal decode. The loader image, its length, the reset target and the exit address are all parameters.

Top module: `boot_rom_emu`

## Requirements
- R1: After reset, `startup_mode` is 1, `boot_done` is 0, `data_oe` is 0, and the first byte delivered is byte 0 of the stream.
- R2: `data_oe` is 1 only while `rom_ce_n` is 0. It returns to 0 in the first cycle in which `rom_ce_n` is 1.
- R3: The pointer advances exactly once per enable strobe, in the cycle after the strobe ends. The address value within the upper range has no effect on which byte is delivered.
- R4: Stream bytes 0 and 1 are the low and high bytes of `RESET_VEC` (default 16'h8000). Bit 15 of `RESET_VEC` is 1.
- R5: For each loader byte k, stream bytes 2+4k .. 5+4k are 8'hA9, loader byte k, 8'h85, and k. Loader byte k is `LOADER_IMAGE[8k+7:8k]`.
- R6: The last three stream bytes are 8'h4C, 8'h00, 8'h00. `boot_done` rises when the strobe carrying the last byte ends. From then on `data_oe` stays 0.
- R7: While `startup_mode` is 1, `rom_ce_n` is 0 in a cycle with `bus_valid`=1, `cpu_rw`=1 and `cpu_addr[15]`=1. A read below 16'h8000 leaves `rom_ce_n` at 1 and does not advance the pointer.
- R8: A write cycle to `EXIT_ADDR` (default 16'h5000) clears `startup_mode` from the next cycle on. A write to any other address leaves the flag set. With the flag clear, upper-range reads leave `rom_ce_n` at 1.
- R9: A write cycle (`cpu_rw`=0) never makes `rom_ce_n` 0 or `data_oe` 1, even in the upper range.
- R10: When a write to `EXIT_ADDR` falls in the same cycle as the pointer advance that ends the stream, both take effect: `boot_done` becomes 1 and `startup_mode` becomes 0.
- R11: A strobe held for several cycles delivers the same byte throughout and advances the pointer only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than CPU bus cycles |
| rst_n | input | 1 | CPU reset, active low |
| bus_valid | input | 1 | High while the CPU bus cycle carries a valid address |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address, used only for the startup and exit decode |
| rom_ce_n | output | 1 | Generated emulator enable, active low |
| data_out | output | 8 | Byte offered to the data bus |
| data_oe | output | 1 | Drive enable for the data pads; 0 means high impedance |
| startup_mode | output | 1 | 1 while the upper range is routed to the emulator |
| boot_done | output | 1 | 1 once the final jump byte has been delivered |

## Verification
The pointer advance that follows the final strobe and a write to the exit register can land on the same clock edge. The advance happens in the cycle after the enable drops, and the CPU can already be writing in that cycle. The bench provokes this by ending the last read strobe and presenting the exit write in the very next cycle. It then checks at the ports that `boot_done` is 1 and `startup_mode` is 0 together. It also checks that the write cycle, which is not a read, neither enabled the emulator nor moved the stream a second time.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

    localparam logic [7:0] OP_LDA_IMM = 8'hA9;
    localparam logic [7:0] OP_STA_ZP  = 8'h85;
    localparam logic [7:0] OP_JMP_ABS = 8'h4C;

    typedef struct packed {
        logic startup;
    } decode_state_t;

endpackage

// File: rtl/boot_decode.sv
module boot_decode
    import boot_rom_pkg::*;
#(
    parameter logic [15:0] EXIT_ADDR = 16'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid_i,
    input  logic        cpu_rw_i,
    input  logic [15:0] cpu_addr_i,
    output logic        ce_n_o,
    output logic        startup_o
);

    decode_state_t st_d, st_q;
    logic          exit_wr;

    always_comb begin
        st_d    = st_q;
        exit_wr = bus_valid_i && !cpu_rw_i && (cpu_addr_i == EXIT_ADDR);
        if (exit_wr) begin
            st_d.startup = 1'b0;
        end
        ce_n_o    = !(st_q.startup && bus_valid_i && cpu_rw_i && cpu_addr_i[15]);
        startup_o = st_q.startup;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.startup <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: once left, startup mode is never re-entered without reset
    a_r8_startup_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.startup |=> !st_q.startup);

endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer #(
    parameter int STREAM_LEN = 21,
    parameter int PTR_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             oe_o,
    output logic             done_o
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(STREAM_LEN - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             ce_seen;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       advance;

    always_comb begin
        st_d         = st_q;
        st_d.ce_seen = enable_i;
        advance      = st_q.ce_seen && !enable_i && !st_q.done;
        if (advance) begin
            if (st_q.ptr == LAST_IDX) begin
                st_d.done = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        ptr_o  = st_q.ptr;
        oe_o   = enable_i && !st_q.done;
        done_o = st_q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr     <= '0;
            st_q.ce_seen <= 1'b0;
            st_q.done    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the pointer only ever moves forward by one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ptr != $past(st_q.ptr)) |-> (st_q.ptr == $past(st_q.ptr) + 1'b1));

    // R6: completion is sticky until reset
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done);

    // R11: a held strobe keeps the same byte index
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && st_q.ce_seen) |-> $stable(st_q.ptr));

endmodule

// File: rtl/boot_image.sv
module boot_image
    import boot_rom_pkg::*;
#(
    parameter int                         LOADER_BYTES = 4,
    parameter logic [LOADER_BYTES*8-1:0]  LOADER_IMAGE = 32'h6A5C3E12,
    parameter logic [15:0]                RESET_VEC    = 16'h8000,
    parameter int                         PTR_W        = 5
) (
    input  logic [PTR_W-1:0] idx_i,
    output logic [7:0]       byte_o
);

    localparam int BODY_END   = 2 + 4 * LOADER_BYTES;
    localparam int STREAM_LEN = BODY_END + 3;
    localparam int DEPTH      = 1 << PTR_W;

    function automatic logic [7:0] stream_byte(input int i);
        int slot;
        int phase;
        if (i == 0) begin
            return RESET_VEC[7:0];
        end else if (i == 1) begin
            return RESET_VEC[15:8];
        end else if (i < BODY_END) begin
            slot  = (i - 2) / 4;
            phase = (i - 2) % 4;
            case (phase)
                0:       return OP_LDA_IMM;
                1:       return LOADER_IMAGE[slot*8 +: 8];
                2:       return OP_STA_ZP;
                default: return 8'(slot);
            endcase
        end else if (i == BODY_END) begin
            return OP_JMP_ABS;
        end
        return 8'h00;
    endfunction

    logic [7:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        if (g < STREAM_LEN) begin : g_used
            assign table_w[g] = stream_byte(g);
        end else begin : g_pad
            assign table_w[g] = 8'h00;
        end
    end

    assign byte_o = table_w[idx_i];

endmodule

// File: rtl/boot_rom_emu.sv
module boot_rom_emu #(
    parameter int                         LOADER_BYTES = 4,
    parameter logic [LOADER_BYTES*8-1:0]  LOADER_IMAGE = 32'h6A5C3E12,
    parameter logic [15:0]                RESET_VEC    = 16'h8000,
    parameter logic [15:0]                EXIT_ADDR    = 16'h5000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        cpu_rw,
    input  logic [15:0] cpu_addr,
    output logic        rom_ce_n,
    output logic [7:0]  data_out,
    output logic        data_oe,
    output logic        startup_mode,
    output logic        boot_done
);

    localparam int STREAM_LEN = 2 + 4 * LOADER_BYTES + 3;
    localparam int PTR_W      = $clog2(STREAM_LEN);

    logic             ce_n_w;
    logic [PTR_W-1:0] ptr_w;

    boot_decode #(.EXIT_ADDR(EXIT_ADDR)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid_i(bus_valid),
        .cpu_rw_i   (cpu_rw),
        .cpu_addr_i (cpu_addr),
        .ce_n_o     (ce_n_w),
        .startup_o  (startup_mode)
    );

    boot_sequencer #(.STREAM_LEN(STREAM_LEN), .PTR_W(PTR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable_i(!ce_n_w),
        .ptr_o   (ptr_w),
        .oe_o    (data_oe),
        .done_o  (boot_done)
    );

    boot_image #(
        .LOADER_BYTES(LOADER_BYTES),
        .LOADER_IMAGE(LOADER_IMAGE),
        .RESET_VEC   (RESET_VEC),
        .PTR_W       (PTR_W)
    ) u_image (
        .idx_i (ptr_w),
        .byte_o(data_out)
    );

    assign rom_ce_n = ce_n_w;

    // R2: the pads are driven only under an active enable
    a_r2_oe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !rom_ce_n);

    // R9: a CPU write never turns the drivers on
    a_r9_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rw |-> !data_oe);

    // R7: the enable never appears outside the upper range
    a_r7_upper_only: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> (cpu_addr[15] && startup_mode));

endmodule

// File: tb/tb_boot_rom_emu.sv
module tb_boot_rom_emu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        cpu_rw = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        rom_ce_n;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        startup_mode;
    logic        boot_done;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    boot_rom_emu dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .cpu_rw      (cpu_rw),
        .cpu_addr    (cpu_addr),
        .rom_ce_n    (rom_ce_n),
        .data_out    (data_out),
        .data_oe     (data_oe),
        .startup_mode(startup_mode),
        .boot_done   (boot_done)
    );

    // {strobe address, expected byte}; addresses vary to show they are ignored
    localparam int NSTREAM = 21;
    localparam logic [23:0] VEC [NSTREAM] = '{
        {16'hFFFC, 8'h00}, {16'hFFFD, 8'h80}, {16'h8000, 8'hA9}, {16'h8001, 8'h12},
        {16'hC123, 8'h85}, {16'h9999, 8'h00}, {16'hFFFF, 8'hA9}, {16'hA000, 8'h3E},
        {16'h8000, 8'h85}, {16'hE001, 8'h01}, {16'hB0B0, 8'hA9}, {16'h8002, 8'h5C},
        {16'h8003, 8'h85}, {16'hD7D7, 8'h02}, {16'h8004, 8'hA9}, {16'hF000, 8'h6A},
        {16'h8005, 8'h85}, {16'h8006, 8'h03}, {16'h8007, 8'h4C}, {16'h8008, 8'h00},
        {16'h8009, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        bus_valid = 1'b0;
        cpu_rw    = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one read strobe of one cycle, then one idle cycle; samples mid-cycle
    task automatic read_strobe(input logic [15:0] a, output logic [7:0] b,
                               output logic oe, output logic ce_n);
        @(negedge clk);
        bus_valid = 1'b1;
        cpu_rw    = 1'b1;
        cpu_addr  = a;
        #5;
        b    = data_out;
        oe   = data_oe;
        ce_n = rom_ce_n;
        @(negedge clk);
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic write_cycle(input logic [15:0] a);
        @(negedge clk);
        bus_valid = 1'b1;
        cpu_rw    = 1'b0;
        cpu_addr  = a;
        #5;
        chk("R9 write ce_n", 16'(rom_ce_n), 16'd1);
        chk("R9 write oe", 16'(data_oe), 16'd0);
        @(negedge clk);
        bus_valid = 1'b0;
        cpu_rw    = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic       oe;
        logic       cen;

        do_reset();
        // R1 reset state
        chk("R1 startup", 16'(startup_mode), 16'd1);
        chk("R1 done", 16'(boot_done), 16'd0);
        chk("R1 oe", 16'(data_oe), 16'd0);
        chk("R1 idle ce_n", 16'(rom_ce_n), 16'd1);

        // R7 low-range read: no enable, no advance
        read_strobe(16'h4000, b, oe, cen);
        chk("R7 low read ce_n", 16'(cen), 16'd1);
        chk("R7 low read oe", 16'(oe), 16'd0);
        // R9 upper-range write: no enable
        write_cycle(16'hC000);
        // R8 write to another address keeps startup
        write_cycle(16'h5001);
        chk("R8 other write keeps startup", 16'(startup_mode), 16'd1);

        // R3 R4 R5 R6 walk the whole stream
        for (int i = 0; i < NSTREAM; i++) begin
            read_strobe(VEC[i][23:8], b, oe, cen);
            chk($sformatf("R7 strobe %0d ce_n", i), 16'(cen), 16'd0);
            chk($sformatf("R2 strobe %0d oe", i), 16'(oe), 16'd1);
            chk($sformatf("R3/R4/R5/R6 byte %0d", i), 16'(b), 16'(VEC[i][7:0]));
            chk($sformatf("R2 released %0d", i), 16'(data_oe), 16'd0);
            if (i < NSTREAM - 1)
                chk($sformatf("R6 not done %0d", i), 16'(boot_done), 16'd0);
        end
        chk("R6 done after jump", 16'(boot_done), 16'd1);
        read_strobe(16'h8000, b, oe, cen);
        chk("R6 no drive after done", 16'(oe), 16'd0);
        chk("R7 still enabled in startup", 16'(cen), 16'd0);

        // R8 exit register
        write_cycle(16'h5000);
        chk("R8 startup cleared", 16'(startup_mode), 16'd0);
        read_strobe(16'hFFFC, b, oe, cen);
        chk("R8 upper read ce_n after exit", 16'(cen), 16'd1);
        chk("R8 upper read oe after exit", 16'(oe), 16'd0);

        // R1 reset restores start of stream
        do_reset();
        chk("R1 startup again", 16'(startup_mode), 16'd1);
        chk("R1 done cleared", 16'(boot_done), 16'd0);

        // R11 long strobe
        @(negedge clk);
        bus_valid = 1'b1;
        cpu_rw    = 1'b1;
        cpu_addr  = 16'hFFFC;
        for (int k = 0; k < 4; k++) begin
            #5;
            chk($sformatf("R11 held byte cycle %0d", k), 16'(data_out), 16'h00);
            chk($sformatf("R11 held oe cycle %0d", k), 16'(data_oe), 16'd1);
            @(negedge clk);
        end
        bus_valid = 1'b0;
        @(negedge clk);
        read_strobe(16'hFFFD, b, oe, cen);
        chk("R11 single advance", 16'(b), 16'h80);

        // advance to the last byte
        for (int i = 2; i < NSTREAM - 1; i++) begin
            read_strobe(VEC[i][23:8], b, oe, cen);
            chk($sformatf("R3 rerun byte %0d", i), 16'(b), 16'(VEC[i][7:0]));
        end

        // R10 last strobe, exit write in the release cycle
        @(negedge clk);
        bus_valid = 1'b1;
        cpu_rw    = 1'b1;
        cpu_addr  = 16'h8000;
        #5;
        chk("R10 last byte", 16'(data_out), 16'h00);
        chk("R10 last oe", 16'(data_oe), 16'd1);
        @(negedge clk);
        cpu_rw   = 1'b0;
        cpu_addr = 16'h5000;
        #5;
        chk("R10 write cycle oe", 16'(data_oe), 16'd0);
        chk("R10 write cycle ce_n", 16'(rom_ce_n), 16'd1);
        @(negedge clk);
        bus_valid = 1'b0;
        cpu_rw    = 1'b1;
        #5;
        chk("R10 done", 16'(boot_done), 16'd1);
        chk("R10 startup cleared", 16'(startup_mode), 16'd0);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule